// File: doc/BRIEF.md
# Coarse Pulsewidth Code Generator

This block measures how many coarse delay steps fit inside one high phase of a reference signal. The coarse delay line is split into four groups of four taps. The taps that close groups one, two and three each send a strobe. The block keeps a one-hot group code. The code moves up one position when the strobe that closes the current group arrives while the reference is still high. The reference's fall ends the measurement and raises a finish flag.

When the measurement finishes, the block reads four in-group tap samples taken from the selected group. It adds their offset to the base of the detected group, which gives a 4-bit binary count of coarse delays. No thermometer decoder over the whole line is needed.

After finishing, the block lowers the enables of every group above the detected one, so that unused delay cells can be switched off. A start pulse re-arms the block for a new measurement. The delay cells themselves are not part of the block; they appear only as strobes and tap samples.

Top module: `cpwg_coarse_code`

## Requirements
- R1: After reset or a start pulse the block is in its idle state: group code 0001, finish flag 0, coarse count 0000, group enables 1111.
- R2: The group code moves at most one position per clock. It moves when the reference is sampled high, the measurement is not finished, and the strobe that closes the active group is set. Bit 0 of the strobe input belongs to tap 4 and moves the code 0001→0010. Bit 1 belongs to tap 8 and moves 0010→0100. Bit 2 belongs to tap 12 and moves 0100→1000.
- R3: The group code does not change on any of these: a strobe that does not close the active group, a strobe while the reference is low, or a strobe after the finish flag is set.
- R4: The finish flag is set on the first clock edge where the reference is sampled low after it was sampled high since the last start or reset. A low reference with no earlier high phase does not finish the measurement.
- R5: On the finishing edge the coarse count is latched as base + offset. The base is 0, 4, 8 or 12 for group codes 0001, 0010, 0100 and 1000. The offset is the index (0 to 3) of the highest set bit of the tap-sample input, bit 0 standing for the first tap of the group, or 0 if no bit is set. For example, group 0100 with taps 1000 gives 1011.
- R6: Once the finish flag is set, the flag, the group code and the coarse count stay unchanged until the next start or reset, whatever the reference, strobes and taps do.
- R7: While not finished, all four group enables are 1. After finishing, enable bit k is 1 exactly when k is less than or equal to the position of the detected group. For example, group 0010 gives enables 0011.
- R8: A start pulse takes priority over a strobe or a reference fall in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Re-arm pulse for a new measurement |
| ref_lvl | input | 1 | Level of the reference pulse |
| bnd_stb | input | 3 | Group-closing tap strobes (taps 4, 8, 12) |
| tap_hit | input | 4 | Samples of the four taps of the active group |
| grp_code | output | 4 | One-hot detected group |
| done | output | 1 | Measurement finished |
| coarse_cnt | output | 4 | Binary count of coarse delays |
| grp_en | output | 4 | Per-group delay-cell enables |

## Verification
The bench drives a strobe that belongs to a later group while the first group is active. A design that advances on any strobe would jump ahead and report a count that is too long. It fires all three strobes together and checks that the code moves only one step per clock. It also fires strobes and a second reference fall after finishing. A design that forgets to freeze would then lose the measured count. Finally, it lowers the reference without any high phase and combines start with a fall in the same cycle, which catches a finish flag that fires spuriously or loses to start.

// File: rtl/cpwg_pkg.sv
package cpwg_pkg;
  parameter int unsigned GROUPS = 4;
  parameter int unsigned TAPS   = 4;
  localparam int unsigned CNT_W = $clog2(GROUPS * TAPS);
  localparam int unsigned IDX_W = $clog2(GROUPS);
  localparam int unsigned OFS_W = $clog2(TAPS);

  typedef logic [GROUPS-1:0] grp_t;
  typedef logic [GROUPS-2:0] stb_t;
  typedef logic [TAPS-1:0]   tap_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  // position of the set bit of a one-hot group code
  function automatic logic [IDX_W-1:0] grp_index(grp_t c);
    grp_index = '0;
    for (int i = 0; i < GROUPS; i++)
      if (c[i]) grp_index = IDX_W'(i);
  endfunction

  // highest set tap sample, zero when none is set
  function automatic logic [OFS_W-1:0] tap_offset(tap_t h);
    tap_offset = '0;
    for (int i = 0; i < TAPS; i++)
      if (h[i]) tap_offset = OFS_W'(i);
  endfunction

  // coarse delay count: group base plus in-group offset
  function automatic cnt_t coarse_sum(grp_t c, tap_t h);
    return cnt_t'(grp_index(c)) * cnt_t'(TAPS) + cnt_t'(tap_offset(h));
  endfunction

  // group code after one clock: moves up only on the strobe closing it
  function automatic grp_t next_group(grp_t c, stb_t s);
    if ((c[GROUPS-2:0] & s) != '0) return grp_t'(c << 1);
    return c;
  endfunction

  // enables for groups at or below the detected one
  function automatic grp_t group_mask(grp_t c);
    logic [IDX_W-1:0] idx;
    idx = grp_index(c);
    for (int i = 0; i < GROUPS; i++)
      group_mask[i] = (IDX_W'(i) <= idx);
  endfunction
endpackage

// File: rtl/cpwg_group_track.sv
module cpwg_group_track
  import cpwg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ref_lvl,
  input  stb_t bnd_stb,
  output grp_t grp_code,
  output logic done,
  output logic fall_evt,
  output logic adv_evt
);
  logic ref_seen;
  grp_t grp_nxt;

  assign grp_nxt  = next_group(grp_code, bnd_stb);
  assign fall_evt = !start && !done && ref_seen && !ref_lvl;
  assign adv_evt  = !start && !done && ref_lvl && (grp_nxt != grp_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_code <= grp_t'(1);
      done     <= 1'b0;
      ref_seen <= 1'b0;
    end else if (start) begin
      grp_code <= grp_t'(1);
      done     <= 1'b0;
      ref_seen <= 1'b0;
    end else if (!done) begin
      if (ref_lvl) begin
        ref_seen <= 1'b1;
        grp_code <= grp_nxt;
      end else if (ref_seen) begin
        done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cpwg_count_latch.sv
module cpwg_count_latch
  import cpwg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic fall_evt,
  input  grp_t grp_code,
  input  tap_t tap_hit,
  output cnt_t coarse_cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        coarse_cnt <= '0;
    else if (start)    coarse_cnt <= '0;
    else if (fall_evt) coarse_cnt <= coarse_sum(grp_code, tap_hit);
  end
endmodule

// File: rtl/cpwg_power_gate.sv
module cpwg_power_gate
  import cpwg_pkg::*;
(
  input  logic done,
  input  grp_t grp_code,
  output grp_t grp_en
);
  always_comb grp_en = done ? group_mask(grp_code) : '1;
endmodule

// File: rtl/cpwg_coarse_code.sv
module cpwg_coarse_code
  import cpwg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        ref_lvl,
  input  logic [2:0]  bnd_stb,
  input  logic [3:0]  tap_hit,
  output logic [3:0]  grp_code,
  output logic        done,
  output logic [3:0]  coarse_cnt,
  output logic [3:0]  grp_en
);
  logic fall_evt;
  logic adv_evt;

  cpwg_group_track u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .ref_lvl  (ref_lvl),
    .bnd_stb  (bnd_stb),
    .grp_code (grp_code),
    .done     (done),
    .fall_evt (fall_evt),
    .adv_evt  (adv_evt)
  );

  cpwg_count_latch u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .fall_evt   (fall_evt),
    .grp_code   (grp_code),
    .tap_hit    (tap_hit),
    .coarse_cnt (coarse_cnt)
  );

  cpwg_power_gate u_gate (
    .done     (done),
    .grp_code (grp_code),
    .grp_en   (grp_en)
  );
endmodule

// File: rtl/cpwg_checker.sv
module cpwg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       ref_lvl,
  input logic [3:0] grp_code,
  input logic       done,
  input logic [3:0] coarse_cnt,
  input logic [3:0] grp_en,
  input logic       adv_evt,
  input logic       fall_evt
);
  // R1 / R8: start wins and returns the idle state
  a_r1_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (grp_code == 4'b0001) && !done && (coarse_cnt == 4'd0) && (grp_en == 4'b1111));

  // R2: group code stays one-hot
  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grp_code) == 1);

  // R2: an advance is a single step upward
  a_r2_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt |=> grp_code == ($past(grp_code) << 1));

  // R3: low reference never moves the group
  a_r3_low_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_lvl && !start) |=> $stable(grp_code));

  // R4: finish only follows a sampled-low reference
  a_r4_finish_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(!ref_lvl) && $past(fall_evt));

  // R6: finished state is frozen until start
  a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done && $stable(grp_code) && $stable(coarse_cnt));

  // R7: full enables while measuring
  a_r7_all_on: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> grp_en == 4'b1111);

  // R7: after finishing, the detected group and group 0 stay enabled
  a_r7_kept_on: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> grp_en[0] && ((grp_en & grp_code) == grp_code));
endmodule

bind cpwg_coarse_code cpwg_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .ref_lvl    (ref_lvl),
  .grp_code   (grp_code),
  .done       (done),
  .coarse_cnt (coarse_cnt),
  .grp_en     (grp_en),
  .adv_evt    (adv_evt),
  .fall_evt   (fall_evt)
);

// File: tb/cpwg_coarse_code_tb_top.sv
`timescale 1ns/1ps
module cpwg_coarse_code_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       ref_lvl = 1'b0;
  logic [2:0] bnd_stb = 3'b000;
  logic [3:0] tap_hit = 4'b0000;
  logic [3:0] grp_code;
  logic       done;
  logic [3:0] coarse_cnt;
  logic [3:0] grp_en;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cpwg_coarse_code dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_lvl(ref_lvl),
    .bnd_stb(bnd_stb), .tap_hit(tap_hit), .grp_code(grp_code),
    .done(done), .coarse_cnt(coarse_cnt), .grp_en(grp_en)
  );

  // {strobes fired [17:16], taps [15:12], group [11:8], count [7:4], enables [3:0]}
  localparam logic [17:0] VEC [8] = '{
    {2'd2, 4'b1000, 4'b0100, 4'b1011, 4'b0111},
    {2'd0, 4'b0001, 4'b0001, 4'b0000, 4'b0001},
    {2'd1, 4'b0100, 4'b0010, 4'b0110, 4'b0011},
    {2'd3, 4'b0010, 4'b1000, 4'b1101, 4'b1111},
    {2'd3, 4'b1000, 4'b1000, 4'b1111, 4'b1111},
    {2'd0, 4'b0000, 4'b0001, 4'b0000, 4'b0001},
    {2'd2, 4'b1010, 4'b0100, 4'b1011, 4'b0111},
    {2'd1, 4'b0000, 4'b0010, 4'b0100, 4'b0011}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_start();
    start = 1'b1; tick(); start = 1'b0;
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  end

  initial begin
    tick();
    // R1 reset state
    chk("R1 grp", grp_code, 4'b0001);
    chk("R1 done", {3'b0, done}, 4'b0000);
    chk("R1 cnt", coarse_cnt, 4'b0000);
    chk("R1 en", grp_en, 4'b1111);
    rst_n = 1'b1; tick();

    // table of measurements: R2, R5, R7
    for (int i = 0; i < 8; i++) begin
      int n;
      n = int'(VEC[i][17:16]);
      do_start();
      ref_lvl = 1'b1; tick();
      for (int k = 0; k < n; k++) begin
        bnd_stb = 3'(1 << k); tick();
      end
      bnd_stb = 3'b000;
      chk("R7 en while measuring", grp_en, 4'b1111);
      chk("R2 grp during pulse", grp_code, VEC[i][11:8]);
      tap_hit = VEC[i][15:12];
      ref_lvl = 1'b0; tick();
      chk("R4 done after fall", {3'b0, done}, 4'b0001);
      chk("R5 coarse count", coarse_cnt, VEC[i][7:4]);
      chk("R7 en after finish", grp_en, VEC[i][3:0]);
      tap_hit = 4'b0000;
    end

    // R3 strobe of a later group is ignored; R2 single step on all strobes
    do_start();
    chk("R1 start idle cnt", coarse_cnt, 4'b0000);
    ref_lvl = 1'b1; bnd_stb = 3'b010; tick();
    chk("R3 foreign strobe", grp_code, 4'b0001);
    bnd_stb = 3'b111; tick();
    chk("R2 step 1", grp_code, 4'b0010);
    tick();
    chk("R2 step 2", grp_code, 4'b0100);
    tick();
    chk("R2 step 3", grp_code, 4'b1000);
    tick();
    chk("R2 top stays", grp_code, 4'b1000);
    bnd_stb = 3'b000; ref_lvl = 1'b0; tick();
    chk("R4 done", {3'b0, done}, 4'b0001);
    chk("R5 top base", coarse_cnt, 4'b1100);

    // R6 frozen after finish
    ref_lvl = 1'b1; bnd_stb = 3'b111; tap_hit = 4'b1111; tick();
    bnd_stb = 3'b000; ref_lvl = 1'b0; tick();
    chk("R6 grp frozen", grp_code, 4'b1000);
    chk("R6 cnt frozen", coarse_cnt, 4'b1100);
    chk("R6 done held", {3'b0, done}, 4'b0001);
    tap_hit = 4'b0000;

    // R3 strobe while low; R4 no finish without a high phase
    do_start();
    bnd_stb = 3'b001; tick(); tick();
    bnd_stb = 3'b000;
    chk("R3 low strobe", grp_code, 4'b0001);
    chk("R4 no high phase", {3'b0, done}, 4'b0000);

    // R8 start beats strobe and fall
    ref_lvl = 1'b1; tick();
    bnd_stb = 3'b001; start = 1'b1; tick();
    chk("R8 start over strobe", grp_code, 4'b0001);
    bnd_stb = 3'b000; start = 1'b0; tick();
    ref_lvl = 1'b0; start = 1'b1; tick();
    chk("R8 start over fall", {3'b0, done}, 4'b0000);
    start = 1'b0; tick();
    chk("R4 no finish after start", {3'b0, done}, 4'b0000);

    finished = 1'b1;
    summary();
  end
endmodule